// File: doc/BRIEF.md
# Two-Step Sub-Ranging Conversion Sequencer

This block sequences a sub-ranging analog-to-digital conversion that uses one small flash quantizer twice, so that the result is twice as wide as that quantizer. A start request opens a coarse pass. The upper nibble of the result comes from the first valid flash reading. That nibble then goes out, shifted to the top of a full-width DAC code, so that external analog circuitry can subtract it from the held input and form the residue.

A residue-select output steers the flash input multiplexer onto the residue. After a fixed settling interval the block takes a fine reading from the same flash stage. It joins the two readings into the final code and marks completion with a single-cycle pulse.

The flash stage, the DAC and the analog subtraction lie outside the block and are modelled in the testbench.

Top module: `subrange_seq`

## Requirements
- R1: After reset, busy_o, done_o and resid_sel_o are 0, and dac_code_o and result_o are all zeros.
- R2: A start_i pulse while idle begins a conversion. On the next cycle busy_o is 1, resid_sel_o is 0 and dac_code_o is 0 for the coarse pass.
- R3: The coarse nibble is taken only on a clock edge where flash_vld_i is 1. Flash codes offered with flash_vld_i low are discarded.
- R4: Through the settle and fine phases resid_sel_o is 1 and dac_code_o equals the coarse nibble in bits [7:4] with bits [3:0] zero. Outside those phases dac_code_o is 0.
- R5: The settle phase lasts exactly SETTLE_CYC clock cycles (default 4). Any flash reading offered in that phase is ignored, whether flash_vld_i is high or low.
- R6: The fine nibble is taken only on a clock edge where flash_vld_i is 1, once the settle phase has ended.
- R7: result_o equals coarse_nibble*16 + fine_nibble, with the coarse reading in bits [7:4] and the fine reading in bits [3:0].
- R8: done_o is high for exactly one cycle, and busy_o falls on the cycle after done_o. With flash_vld_i held high, done_o is first seen SETTLE_CYC+3 cycles after the clock edge that samples start_i.
- R9: A start_i pulse while busy_o is 1 has no effect. The running conversion keeps its timing and its result.
- R10: result_o keeps its value from one completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a conversion |
| flash_code_i | input | 4 | Reading from the shared flash stage |
| flash_vld_i | input | 1 | Qualifies flash_code_i in the current cycle |
| dac_code_o | output | 8 | Feedback code for the full-width DAC |
| resid_sel_o | output | 1 | 1 selects the residue as the flash input |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Combined conversion result |

## Verification
The assertions assume that rst_n is held low before the first edge, that start_i and flash_vld_i are free of unknowns once reset is released, and that flash_code_i only carries meaning when flash_vld_i is high. The bench keeps to these assumptions. It drives every input at the falling edge from one task. Its flash model returns deliberately wrong codes whenever valid is low and for the whole settle window, so an early or unqualified capture corrupts the result, while every code the model offers with valid high is the ideal coarse or residue nibble of the swept input.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

    // conversion phases, in the order a conversion visits them
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COARSE = 3'd1,
        ST_SETTLE = 3'd2,
        ST_FINE   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/subrange_settle_timer.sv
module subrange_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = run_i && (cnt_q == LAST_VAL);
        if (!run_i || last_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

    // R5
    cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/subrange_ctrl.sv
module subrange_ctrl
    import subrange_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [STEP_W-1:0]     flash_code_i,
    input  logic                  flash_vld_i,
    input  logic                  settle_last_i,
    output seq_state_e            state_o,
    output logic [STEP_W-1:0]     coarse_o,
    output logic [2*STEP_W-1:0]   result_o
);
    localparam int RES_W = 2 * STEP_W;

    typedef struct packed {
        seq_state_e         st;
        logic [STEP_W-1:0]  coarse;
        logic [RES_W-1:0]   result;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE:   if (start_i) r_d.st = ST_COARSE;
            ST_COARSE: if (flash_vld_i) begin
                r_d.coarse = flash_code_i;
                r_d.st     = ST_SETTLE;
            end
            ST_SETTLE: if (settle_last_i) r_d.st = ST_FINE;
            ST_FINE:   if (flash_vld_i) begin
                r_d.result = {r_q.coarse, flash_code_i};
                r_d.st     = ST_DONE;
            end
            ST_DONE:   r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, coarse: '0, result: '0};
        else        r_q <= r_d;
    end

    assign state_o  = r_q.st;
    assign coarse_o = r_q.coarse;
    assign result_o = r_q.result;

    // R3
    coarse_wait_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COARSE && !flash_vld_i) |=> (r_q.st == ST_COARSE && $stable(r_q.coarse)));

    // R6
    fine_wait_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FINE && !flash_vld_i) |=> r_q.st == ST_FINE);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_COARSE) |=> r_q.st != ST_COARSE);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_FINE) |=> $stable(r_q.result));

    // R7
    result_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FINE && flash_vld_i) |=> r_q.result[RES_W-1:STEP_W] == $past(r_q.coarse));
endmodule

// File: rtl/subrange_outdec.sv
module subrange_outdec
    import subrange_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  seq_state_e            state_i,
    input  logic [STEP_W-1:0]     coarse_i,
    output logic [2*STEP_W-1:0]   dac_code_o,
    output logic                  resid_sel_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  settle_run_o
);
    always_comb begin
        resid_sel_o  = (state_i == ST_SETTLE) || (state_i == ST_FINE);
        busy_o       = (state_i != ST_IDLE);
        done_o       = (state_i == ST_DONE);
        settle_run_o = (state_i == ST_SETTLE);
        dac_code_o   = resid_sel_o ? {coarse_i, {STEP_W{1'b0}}} : '0;
    end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
    import subrange_pkg::*;
#(
    parameter int STEP_W     = 4,
    parameter int SETTLE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [STEP_W-1:0]    flash_code_i,
    input  logic                 flash_vld_i,
    output logic [2*STEP_W-1:0]  dac_code_o,
    output logic                 resid_sel_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [2*STEP_W-1:0]  result_o
);
    seq_state_e        state;
    logic [STEP_W-1:0] coarse;
    logic              settle_run, settle_last;

    subrange_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .flash_code_i  (flash_code_i),
        .flash_vld_i   (flash_vld_i),
        .settle_last_i (settle_last),
        .state_o       (state),
        .coarse_o      (coarse),
        .result_o      (result_o)
    );

    subrange_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (settle_run),
        .last_o (settle_last)
    );

    subrange_outdec #(.STEP_W(STEP_W)) u_dec (
        .state_i      (state),
        .coarse_i     (coarse),
        .dac_code_o   (dac_code_o),
        .resid_sel_o  (resid_sel_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .settle_run_o (settle_run)
    );

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R4
    dac_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resid_sel_o |-> (dac_code_o[STEP_W-1:0] == '0 && $stable(dac_code_o) || $rose(resid_sel_o)));

    // R4
    dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resid_sel_o |-> dac_code_o == '0);

    // R2
    coarse_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !resid_sel_o));
endmodule

// File: tb/sim_subrange_seq.sv
module sim_subrange_seq;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       flash_vld = 1'b0;
    logic [3:0] flash_code;
    logic [7:0] dac_code, result;
    logic       resid_sel, busy, done;
    logic [7:0] vin = 8'h00;
    logic [7:0] res_cnt;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    subrange_seq #(.STEP_W(4), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .flash_code_i(flash_code), .flash_vld_i(flash_vld),
        .dac_code_o(dac_code), .resid_sel_o(resid_sel), .busy_o(busy),
        .done_o(done), .result_o(result)
    );

    // cycles the residue path has been selected, used to model settling
    always_ff @(posedge clk) begin
        if (resid_sel) res_cnt <= res_cnt + 8'd1;
        else           res_cnt <= 8'd0;
    end

    // flash model: wrong codes when not valid or still settling
    always_comb begin
        logic [3:0] good;
        good = resid_sel ? 4'(vin - dac_code) : vin[7:4];
        if (!flash_vld)                          flash_code = ~good;
        else if (resid_sel && res_cnt < SETTLE)  flash_code = ~good;
        else                                     flash_code = good;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input logic [7:0] v, input bit gaps, input int poke);
        int cyc;
        bit seen;
        logic [7:0] held;
        vin = v;
        @(negedge clk);
        start = 1'b1;
        flash_vld = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        seen = 1'b0;
        chk(busy && !resid_sel && dac_code == 0, "R2", {busy, resid_sel, dac_code}, 9'h100);
        while (!done && cyc < 100) begin
            if (resid_sel && !seen) begin
                seen = 1'b1;
                chk(dac_code == {v[7:4], 4'h0}, "R4", dac_code, {v[7:4], 4'h0});
            end
            flash_vld = gaps ? ((cyc % 3) != 1) : 1'b1;
            start = (cyc == poke);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(result == v, "R7", result, v);
        if (!gaps) chk(cyc == SETTLE + 3, "R8", cyc, SETTLE + 3);
        @(negedge clk);
        chk(!done && !busy, "R8", {done, busy}, 0);
        held = result;
        flash_vld = 1'b1;
        @(negedge clk);
        flash_vld = 1'b0;
        @(negedge clk);
        chk(result == held && dac_code == 0 && !busy, "R10", result, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !resid_sel && dac_code == 0 && result == 0, "R1",
            {busy, done, resid_sel, dac_code, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 R5 R8: every input code with valid held high
        for (int v = 0; v < 256; v++) convert(8'(v), 1'b0, 0);
        // R3 R6: valid strobe with gaps
        for (int v = 0; v < 256; v += 5) convert(8'(v), 1'b1, 0);
        // R9: start pulses inside every busy cycle
        for (int p = 1; p <= SETTLE + 2; p++) convert(8'(8'hA5 + 8'(p * 37)), 1'b0, p);
        // R9: start held through a whole gapped conversion
        convert(8'h3C, 1'b1, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule